// File: doc/BRIEF.md
# Supply Supervisor with Reset Stretcher and Watchdog

This block watches a system's supply and a software heartbeat, and from them drives the system reset and a watchdog alarm. A supply-low flag from an outside comparator, or a debounced press on the active-low manual reset line, asserts the system reset. The reset stays asserted for as long as the cause lasts. After the cause clears, it stays asserted for a programmable number of hold cycles. An active-high copy of the reset is also provided.

Software keeps the watchdog quiet by toggling the kick input. Either a rising or a falling transition restarts the count. If the input goes quiet for the whole timeout period, the active-low alarm output drops. The alarm does not reset the system unless it is wired back to the manual reset line outside the block. A separate "floating" flag says the kick line is undriven, and this disables the watchdog. A power-fail compare flag is passed to an active-low power-fail output. The hold time, the debounce window and the timeout are parameters counted in clock cycles. The manual reset line and the kick line are asynchronous, so each passes through a two-flop synchroniser.

Top module: `sup_supervisor`

## Requirements
- R1: While `supply_low_i` is sampled high on a clock edge, `sys_rst_n_o` is low after that edge.
- R2: `sys_rst_n_o` returns high exactly HOLD_CYC edges after the last edge that sampled a reset cause active. A reset cause is supply-low, or a debounced manual reset at 0.
- R3: A manual reset level of 0 that is accepted by the debouncer asserts `sys_rst_n_o`. The reset is held for HOLD_CYC cycles after the debounced level returns to 1.
- R4: After the synchroniser, a change on `man_rst_n_i` is accepted only when the new level has been present for DEB_CYC consecutive edges. A low pulse shorter than that leaves `sys_rst_n_o` high.
- R5: A rising or a falling transition on `wd_kick_i` restarts the watchdog count two edges later. The alarm is released at that point.
- R6: While the system reset is asserted, the watchdog count is held at zero, so no timeout can occur during reset or during the hold period.
- R7: While `wd_float_i` is 1, the watchdog count is held at zero and `wd_alarm_n_o` stays high, unless supply-low is active.
- R8: When WDOG_CYC edges pass after the last clearing edge with no further clear, `wd_alarm_n_o` goes low. It stays low until the next clear.
- R9: `wd_alarm_n_o` is low after any edge that samples `supply_low_i` high. It is high after the first edge that samples it low, without waiting for the hold period.
- R10: A watchdog timeout does not assert `sys_rst_n_o`.
- R11: `sys_rst_o` is always the inverse of `sys_rst_n_o`.
- R12: `pwr_fail_n_o` equals the inverse of `pwr_below_i` as sampled on the previous edge.
- R13: While `rst_n` is low, the outputs are: `sys_rst_n_o`=0, `wd_alarm_n_o`=1 and `pwr_fail_n_o`=1. After `rst_n` rises, the system reset is held for HOLD_CYC further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| supply_low_i | input | 1 | Supply below threshold, synchronous flag |
| man_rst_n_i | input | 1 | Manual reset, active low, asynchronous and may bounce |
| pwr_below_i | input | 1 | Power-fail compare flag, 1 = below threshold |
| wd_kick_i | input | 1 | Watchdog heartbeat, asynchronous |
| wd_float_i | input | 1 | Kick line undriven; disables the watchdog |
| sys_rst_n_o | output | 1 | System reset, active low |
| sys_rst_o | output | 1 | System reset, active high |
| wd_alarm_n_o | output | 1 | Watchdog alarm, active low |
| pwr_fail_n_o | output | 1 | Power-fail indication, active low |

## Verification
The assertions assume that `supply_low_i`, `pwr_below_i` and `wd_float_i` are already synchronous to `clk` and change only between edges. Only the manual reset and kick lines may change at arbitrary times. They also assume that the block reset is held for several cycles at start-up, so that every register has a defined value before any property is enabled. The stimulus changes all inputs on the falling clock edge. Random phases keep supply-low events rare and short, so that hold periods and watchdog timeouts still complete between them. Short manual-reset glitches are drawn on purpose to exercise the debounce window.

// File: rtl/sup_pkg.sv
// Package: shared types for the supervisor.
// Assumes: nothing; holds declarations only.
package sup_pkg;
    // Watchdog state: counting or expired
    typedef enum logic {
        WD_ARMED   = 1'b0,
        WD_EXPIRED = 1'b1
    } wd_state_e;

    // The conditions that can hold the system in reset
    typedef struct packed {
        logic supply_low;
        logic manual;
    } rst_cause_t;
endpackage

// File: rtl/sup_sync.sv
// Module: sup_sync
// A chain of STAGES flops that brings an asynchronous level into the clk domain.
// Assumes: STAGES >= 2. The chain resets to RST_VAL, the idle level of the input.
module sup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= RST_VAL;
                else        chain_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stages pass the value along
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
// Module: sup_debounce
// Accepts a new input level only after it has differed from the accepted
// level on WINDOW consecutive edges. Any return to the accepted level
// restarts the run.
// Assumes: the input is already synchronous. The accepted level resets to 1 (released).
module sup_debounce #(
    parameter int WINDOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o
);
    localparam int CW = $clog2(WINDOW + 1);

    logic          stable_q;
    logic [CW-1:0] run_q;

    // Count the run of differing samples and take the new level at the window's end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b1;
            run_q    <= '0;
        end else if (level_i == stable_q) begin
            run_q    <= '0;
        end else if (run_q == CW'(WINDOW - 1)) begin
            stable_q <= level_i;
            run_q    <= '0;
        end else begin
            run_q    <= run_q + CW'(1);
        end
    end

    assign level_o = stable_q;
endmodule

// File: rtl/sup_rst_stretch.sv
// Module: sup_rst_stretch
// Holds reset active while the trigger is high. After the last edge that
// sees the trigger, it holds reset for HOLD edges more.
// Assumes: HOLD >= 1. The block reset counts as a trigger, so power-up is stretched too.
module sup_rst_stretch #(
    parameter int HOLD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic          active_q;
    logic [CW-1:0] hold_q;

    // Restart the hold on any trigger; release once the hold count is used up
    always_ff @(posedge clk) begin
        if (!rst_n || trig_i) begin
            active_q <= 1'b1;
            hold_q   <= '0;
        end else if (active_q) begin
            if (hold_q == CW'(HOLD - 1)) begin
                active_q <= 1'b0;
                hold_q   <= '0;
            end else begin
                hold_q   <= hold_q + CW'(1);
            end
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/sup_wdog.sv
// Module: sup_wdog
// Watchdog. Both edges of the synchronised kick restart the count. The count
// is also held clear while the system is in reset or the kick line floats.
// After TIMEOUT quiet edges the alarm drops, and it stays low until the next
// clear. The alarm is also forced low by a registered copy of supply-low.
// Assumes: kick_i is synchronous; sys_rst_i comes from a register.
module sup_wdog
    import sup_pkg::*;
#(
    parameter int TIMEOUT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic float_i,
    input  logic sys_rst_i,
    input  logic supply_low_i,
    output logic alarm_n_o
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic          kick_prev_q;
    logic          kick_edge;
    logic          clear;
    logic [CW-1:0] idle_q;
    wd_state_e     state_q;
    logic          low_q;

    assign kick_edge = kick_i ^ kick_prev_q;
    assign clear     = kick_edge | float_i | sys_rst_i;

    // Remember the previous kick level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) kick_prev_q <= 1'b0;
        else        kick_prev_q <= kick_i;
    end

    // Count quiet cycles and expire at the timeout
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idle_q  <= '0;
            state_q <= WD_ARMED;
        end else if (state_q == WD_ARMED) begin
            if (idle_q == CW'(TIMEOUT - 1)) state_q <= WD_EXPIRED;
            else                            idle_q  <= idle_q + CW'(1);
        end
    end

    // Register supply-low so that the alarm is released on the first edge after it clears
    always_ff @(posedge clk) begin
        if (!rst_n) low_q <= 1'b0;
        else        low_q <= supply_low_i;
    end

    assign alarm_n_o = ~((state_q == WD_EXPIRED) | low_q);
endmodule

// File: rtl/sup_supervisor.sv
// Module: sup_supervisor (top)
// Supply supervisor. It combines supply-low and the debounced manual reset
// into a stretched system reset, runs an edge-cleared watchdog with its own
// alarm, and registers the power-fail indication.
// Assumes: supply_low_i, pwr_below_i and wd_float_i are synchronous flags;
// man_rst_n_i and wd_kick_i are asynchronous.
module sup_supervisor
    import sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYC     = 8,
    parameter int HOLD_CYC    = 40,
    parameter int WDOG_CYC    = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low_i,
    input  logic man_rst_n_i,
    input  logic pwr_below_i,
    input  logic wd_kick_i,
    input  logic wd_float_i,
    output logic sys_rst_n_o,
    output logic sys_rst_o,
    output logic wd_alarm_n_o,
    output logic pwr_fail_n_o
);
    logic       mr_sync;
    logic       mr_level;
    logic       kick_sync;
    logic       rst_active;
    logic       pf_n_q;
    rst_cause_t cause;

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) mr_sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(man_rst_n_i), .q_o(mr_sync)
    );

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) kick_sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(wd_kick_i), .q_o(kick_sync)
    );

    sup_debounce #(.WINDOW(DEB_CYC)) mr_deb_i (
        .clk(clk), .rst_n(rst_n), .level_i(mr_sync), .level_o(mr_level)
    );

    // Gather the reset causes
    always_comb begin
        cause.supply_low = supply_low_i;
        cause.manual     = ~mr_level;
    end

    sup_rst_stretch #(.HOLD(HOLD_CYC)) stretch_i (
        .clk(clk), .rst_n(rst_n), .trig_i(|cause), .active_o(rst_active)
    );

    sup_wdog #(.TIMEOUT(WDOG_CYC)) wdog_i (
        .clk(clk), .rst_n(rst_n), .kick_i(kick_sync), .float_i(wd_float_i),
        .sys_rst_i(rst_active), .supply_low_i(supply_low_i), .alarm_n_o(wd_alarm_n_o)
    );

    // Register the power-fail indication
    always_ff @(posedge clk) begin
        if (!rst_n) pf_n_q <= 1'b1;
        else        pf_n_q <= ~pwr_below_i;
    end

    assign sys_rst_n_o  = ~rst_active;
    assign sys_rst_o    = rst_active;
    assign pwr_fail_n_o = pf_n_q;
endmodule

// File: rtl/sup_supervisor_chk.sv
// Module: sup_supervisor_chk
// Port-level properties of the supervisor, bound to every instance of it.
// Assumes: the block reset is held low for at least one edge at start-up.
module sup_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_low_i,
    input logic pwr_below_i,
    input logic wd_float_i,
    input logic sys_rst_n_o,
    input logic sys_rst_o,
    input logic wd_alarm_n_o,
    input logic pwr_fail_n_o
);
    AST_RST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n) sys_rst_o == !sys_rst_n_o); // R11
    AST_LOW_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n) supply_low_i |=> !sys_rst_n_o); // R1
    AST_RELEASE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_rst_n_o) |-> !$past(supply_low_i)); // R2
    AST_LOW_FORCES_ALARM: assert property (@(posedge clk) disable iff (!rst_n) supply_low_i |=> !wd_alarm_n_o); // R9
    AST_ALARM_QUICK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (!supply_low_i && $past(supply_low_i)) |=> wd_alarm_n_o); // R9
    AST_FLOAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (wd_float_i && !supply_low_i) |=> wd_alarm_n_o); // R7
    AST_PF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) pwr_below_i |=> !pwr_fail_n_o); // R12
endmodule

bind sup_supervisor sup_supervisor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low_i), .pwr_below_i(pwr_below_i),
    .wd_float_i(wd_float_i), .sys_rst_n_o(sys_rst_n_o), .sys_rst_o(sys_rst_o),
    .wd_alarm_n_o(wd_alarm_n_o), .pwr_fail_n_o(pwr_fail_n_o)
);

// File: tb/sup_supervisor_tb_top.sv
// Bench for sup_supervisor: directed corner cases, then seeded random phases.
// Every output is compared each cycle against a cycle model built from the requirements.
module sup_supervisor_tb_top;
    localparam int DEB  = 8;
    localparam int HOLD = 40;
    localparam int WDOG = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0, man_rst_n = 1'b1, pwr_below = 1'b0;
    logic kick = 1'b0, kick_float = 1'b0;
    logic sys_rst_n, sys_rst, alarm_n, pf_n;

    int    n_chk = 0, n_bad = 0;
    bit    armed = 1'b0, finished = 1'b0;
    string cur_req = "R13";

    always #2 clk = ~clk;

    sup_supervisor #(.SYNC_STAGES(2), .DEB_CYC(DEB), .HOLD_CYC(HOLD), .WDOG_CYC(WDOG)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_low_i(supply_low), .man_rst_n_i(man_rst_n),
        .pwr_below_i(pwr_below), .wd_kick_i(kick), .wd_float_i(kick_float),
        .sys_rst_n_o(sys_rst_n), .sys_rst_o(sys_rst), .wd_alarm_n_o(alarm_n), .pwr_fail_n_o(pf_n)
    );

    // Cycle model state
    logic m_mr1, m_mr2, m_deb, m_k1, m_k2, m_kp, m_rst, m_low, m_pf;
    int   m_run, m_since, m_idle;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic logic [3:0] expected();
        return {~m_rst, m_rst, ~(m_low | (m_idle >= WDOG)), m_pf};
    endfunction

    // Cycle model of the requirements, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mr1 = 1; m_mr2 = 1; m_deb = 1; m_run = 0;
            m_k1 = 0; m_k2 = 0; m_kp = 0;
            m_rst = 1; m_since = 0; m_idle = 0; m_low = 0; m_pf = 1;
        end else begin
            logic trig, clr, edge_seen;
            edge_seen = m_k2 ^ m_kp;
            clr  = m_rst | edge_seen | kick_float;
            trig = supply_low | ~m_deb;
            if (clr) m_idle = 0; else if (m_idle < WDOG) m_idle++;
            if (trig) m_since = 0; else if (m_since < HOLD) m_since++;
            m_rst = trig || (m_since < HOLD);
            if (m_mr2 == m_deb) m_run = 0;
            else begin
                m_run++;
                if (m_run == DEB) begin m_deb = m_mr2; m_run = 0; end
            end
            m_low = supply_low; m_pf = ~pwr_below;
            m_kp = m_k2; m_k2 = m_k1; m_k1 = kick;
            m_mr2 = m_mr1; m_mr1 = man_rst_n;
        end
        armed = 1'b1;
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed && !finished) begin
            check(cur_req, {sys_rst_n, sys_rst, alarm_n, pf_n}, expected());
            check("R11", {3'b000, sys_rst}, {3'b000, ~sys_rst_n});
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd4711));
        run(5);
        check("R13 reset outputs", {sys_rst_n, alarm_n, pf_n, 1'b0}, 4'b0110);
        rst_n = 1'b1;
        cur_req = "R13 R2 power-up hold";
        run(HOLD + 5);
        check("R13 released", {3'b000, sys_rst_n}, 4'b0001);

        cur_req = "R8 R10 timeout";
        run(WDOG + 10);
        check("R8 alarm low", {3'b000, alarm_n}, 4'b0000);
        check("R10 no reset", {3'b000, sys_rst_n}, 4'b0001);

        cur_req = "R5 rising kick";
        kick = 1'b1; run(3);
        check("R5 cleared", {3'b000, alarm_n}, 4'b0001);
        run(WDOG - 10);
        cur_req = "R5 falling kick";
        kick = 1'b0; run(WDOG - 10);
        check("R5 still high", {3'b000, alarm_n}, 4'b0001);

        cur_req = "R7 floating";
        kick_float = 1'b1; run(WDOG + 20);
        check("R7 alarm high", {3'b000, alarm_n}, 4'b0001);
        kick_float = 1'b0;

        cur_req = "R1 R9 R6 supply low";
        supply_low = 1'b1; run(WDOG + 10);
        check("R1 reset low", {3'b000, sys_rst_n}, 4'b0000);
        check("R9 alarm low", {3'b000, alarm_n}, 4'b0000);
        supply_low = 1'b0; run(1);
        check("R9 quick release", {3'b000, alarm_n}, 4'b0001);
        check("R2 still held", {3'b000, sys_rst_n}, 4'b0000);
        cur_req = "R2 R6 hold";
        run(HOLD + 2);
        check("R2 released", {3'b000, sys_rst_n}, 4'b0001);

        cur_req = "R4 glitch";
        man_rst_n = 1'b0; run(DEB - 2);
        man_rst_n = 1'b1; run(DEB + 10);
        check("R4 glitch ignored", {3'b000, sys_rst_n}, 4'b0001);

        cur_req = "R3 manual press";
        man_rst_n = 1'b0; run(DEB + 10);
        check("R3 reset low", {3'b000, sys_rst_n}, 4'b0000);
        man_rst_n = 1'b1; run(DEB + 4);
        check("R3 hold", {3'b000, sys_rst_n}, 4'b0000);
        run(HOLD + 4);
        check("R3 released", {3'b000, sys_rst_n}, 4'b0001);

        cur_req = "R12 power fail";
        for (int i = 0; i < 20; i++) begin
            pwr_below = (i % 3 == 0);
            run(1);
        end
        pwr_below = 1'b0;

        cur_req = "mixed R1 R3 R4 R5 R7 R8";
        for (int s = 0; s < 60; s++) begin
            int len;
            len        = 1 + ($urandom % 80);
            supply_low = ($urandom % 10) == 0;
            man_rst_n  = ($urandom % 6) != 0;
            kick_float = ($urandom % 5) == 0;
            for (int c = 0; c < len; c++) begin
                pwr_below = ($urandom % 4) == 0;
                if (($urandom % 8) == 0) kick = ~kick;
                if (($urandom % 20) == 0) man_rst_n = ~man_rst_n;
                run(1);
            end
        end
        summary();
    end

    // Watchdog for a hung run
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
        end
    end
endmodule